// File: doc/BRIEF.md
# Laser Array Enable and Recovery Controller

This block turns a handful of slow control pins into one on/off command for a twelve-lane laser transmitter and one "controller ready" status bit. An active-low hold pin acts both as the power-on hold and as the fault-recovery control. Two enable pins of opposite polarity must both be at their active level. The block keeps the array dark until the supply monitor reports good, and then until a programmable on-delay has passed after the hold is released. Any lane that reports a fault latches a shared fault flag. That flag keeps the array dark and the ready bit low until the hold pin is held low for a minimum recovery time.

The hold, enable, supply-good and fault pins are asynchronous. Each passes through a two-flop synchronizer before any logic uses it. Time is measured in ticks of a one-cycle strobe `us_tick`, which comes from the block's own clock domain. The on-delay and recovery windows are therefore parameters in ticks (defaults 15000 and 10, for a 1 µs tick). The signals that leave the block are registered. The pull-ups and pull-downs that make unconnected pins safe are board tie-offs outside this block.

Top module: `laser_guard_ctrl`

## Requirements
- R1: In the running state with no latched fault, `array_on` is 1 only when `hold_n`=1, `emit_en`=1 and `emit_en_n`=0. Every other combination of these three pins gives `array_on`=0.
- R2: `ctl_ready` is 1 in the running state when no fault is latched, whatever the two enable pins are. It is 0 whenever `hold_n` is seen low or a fault is latched, and `array_on`=1 implies `ctl_ready`=1.
- R3: While `pwr_good`=0, both outputs are 0 and ticks advance neither the on-delay nor the recovery count. After `pwr_good` rises, the on-delay starts from zero.
- R4: A 1 on any single bit of `fault_vec` latches a fault, and both outputs are 0 by the fourth rising edge. Removing the fault input does not bring the outputs back.
- R5: A latched fault clears only after `hold_n` has stayed low, with `pwr_good`=1, for at least RECOVER_TICKS ticks. A shorter low pulse, or ticks that arrive while `pwr_good`=0, leave it latched.
- R6: After `hold_n` goes high, `array_on` stays 0 and `ctl_ready` stays 0 until ON_DELAY_TICKS ticks have been counted while the hold stays high. Three cycles after the last of those ticks, both outputs are 1. A low pulse on `hold_n` during the delay restarts the count.
- R7: A change of `hold_n` to 0, of an enable pin to its inactive level, or of `pwr_good` to 0 leaves `array_on` unchanged after the second rising edge and forces it to 0 by the third.
- R8: If a fault bit is still 1 when the recovery window completes, the fault stays latched, because setting takes priority over clearing.
- R9: The synchronous active-high `rst` drives both outputs to 0 and clears the fault latch and both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_n | input | 1 | Asynchronous active-low hold / recovery pin |
| emit_en | input | 1 | Asynchronous active-high enable |
| emit_en_n | input | 1 | Asynchronous active-low enable |
| pwr_good | input | 1 | Asynchronous supply-good flag |
| fault_vec | input | NCH | Asynchronous per-lane fault flags |
| us_tick | input | 1 | One-cycle time-base strobe, clk domain |
| array_on | output | 1 | Registered laser array on command |
| ctl_ready | output | 1 | Registered controller-ready status |

## Verification
The assertions observe the synchronized pin values rather than the raw pins. They assume that each raw pin holds a level long enough to pass through the synchronizer, and that `us_tick` is high for exactly one clock cycle at a time. The bench changes every input only on the falling clock edge and holds each level for at least several cycles. It drives each tick as a single-cycle pulse, and it waits for the hold to reach the synchronized side before it issues recovery ticks. A small configuration of four lanes, a three-tick recovery window and a five-tick on-delay lets the bench sweep every enable combination and every lane's fault. It can also place the tick count one short of each window and exactly at it.

// File: rtl/laser_guard_pkg.sv
package laser_guard_pkg;
  typedef enum logic [1:0] {
    ST_NOPWR = 2'd0,
    ST_HELD  = 2'd1,
    ST_RAMP  = 2'd2,
    ST_RUN   = 2'd3
  } guard_state_t;
endpackage

// File: rtl/lg_sync_bank.sv
module lg_sync_bank #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lg_hold_timer.sv
module lg_hold_timer #(
  parameter int RECOVER_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_s,
  input  logic pwr_s,
  input  logic tick,
  output logic long_low
);
  localparam int CW = $clog2(RECOVER_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RECOVER_TICKS);

  logic [CW-1:0] cnt;

  // counts ticks of an unbroken low hold seen with good supply; saturates
  always_ff @(posedge clk) begin
    if (rst || hold_s || !pwr_s) cnt <= '0;
    else if (tick && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign long_low = (cnt == LIMIT);
endmodule

// File: rtl/lg_fault_latch.sv
module lg_fault_latch #(
  parameter int NCH = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] fault_s,
  input  logic           clr,
  output logic           fault_q
);
  // setting wins over clearing so a persisting fault survives recovery
  always_ff @(posedge clk) begin
    if (rst)           fault_q <= 1'b0;
    else if (|fault_s) fault_q <= 1'b1;
    else if (clr)      fault_q <= 1'b0;
  end
endmodule

// File: rtl/laser_guard_ctrl.sv
module laser_guard_ctrl
  import laser_guard_pkg::*;
#(
  parameter int NCH = 12,
  parameter int SYNC_STAGES = 2,
  parameter int RECOVER_TICKS = 10,
  parameter int ON_DELAY_TICKS = 15000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold_n,
  input  logic           emit_en,
  input  logic           emit_en_n,
  input  logic           pwr_good,
  input  logic [NCH-1:0] fault_vec,
  input  logic           us_tick,
  output logic           array_on,
  output logic           ctl_ready
);
  localparam int AW = NCH + 4;
  localparam logic [AW-1:0] ASYNC_RST = {1'b0, 1'b1, 1'b0, 1'b0, {NCH{1'b0}}};
  localparam int RW = $clog2(ON_DELAY_TICKS + 1);
  localparam logic [RW-1:0] RAMP_LAST = RW'(ON_DELAY_TICKS - 1);

  logic [AW-1:0]  async_bus, sync_bus;
  logic           hold_s, en_s, en_n_s, pwr_s;
  logic [NCH-1:0] fault_s;
  logic           long_low, fault_q;
  guard_state_t   state, state_nx;
  logic [RW-1:0]  ramp_cnt;
  logic           array_on_q, ctl_ready_q;

  assign async_bus = {pwr_good, emit_en_n, emit_en, hold_n, fault_vec};

  lg_sync_bank #(.W(AW), .STAGES(SYNC_STAGES), .RST_VAL(ASYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(async_bus), .q(sync_bus)
  );

  assign fault_s = sync_bus[NCH-1:0];
  assign hold_s  = sync_bus[NCH];
  assign en_s    = sync_bus[NCH+1];
  assign en_n_s  = sync_bus[NCH+2];
  assign pwr_s   = sync_bus[NCH+3];

  lg_hold_timer #(.RECOVER_TICKS(RECOVER_TICKS)) u_hold (
    .clk(clk), .rst(rst), .hold_s(hold_s), .pwr_s(pwr_s),
    .tick(us_tick), .long_low(long_low)
  );

  lg_fault_latch #(.NCH(NCH)) u_fault (
    .clk(clk), .rst(rst), .fault_s(fault_s), .clr(long_low), .fault_q(fault_q)
  );

  always_comb begin
    state_nx = state;
    if (!pwr_s) begin
      state_nx = ST_NOPWR;
    end else begin
      case (state)
        ST_NOPWR: state_nx = ST_HELD;
        ST_HELD:  if (hold_s) state_nx = ST_RAMP;
        ST_RAMP: begin
          if (!hold_s) state_nx = ST_HELD;
          else if (us_tick && ramp_cnt == RAMP_LAST) state_nx = ST_RUN;
        end
        ST_RUN:   if (!hold_s) state_nx = ST_HELD;
        default:  state_nx = ST_NOPWR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_NOPWR;
      ramp_cnt <= '0;
    end else begin
      state <= state_nx;
      if (state != ST_RAMP || !hold_s || !pwr_s) ramp_cnt <= '0;
      else if (us_tick) ramp_cnt <= ramp_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      array_on_q  <= 1'b0;
      ctl_ready_q <= 1'b0;
    end else begin
      ctl_ready_q <= (state == ST_RUN) && hold_s && pwr_s && !fault_q;
      array_on_q  <= (state == ST_RUN) && hold_s && pwr_s && !fault_q
                     && en_s && !en_n_s;
    end
  end

  assign array_on  = array_on_q;
  assign ctl_ready = ctl_ready_q;
endmodule

// File: rtl/laser_guard_chk.sv
module laser_guard_chk #(
  parameter int NCH = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           hold_s,
  input logic           en_s,
  input logic           en_n_s,
  input logic           pwr_s,
  input logic [NCH-1:0] fault_s,
  input logic           fault_q,
  input logic           long_low,
  input logic           array_on,
  input logic           ctl_ready
);
  assert_held_off_R1: assert property (@(posedge clk) disable iff (rst)
    !hold_s |=> !array_on);
  assert_enable_gate_R1: assert property (@(posedge clk) disable iff (rst)
    (!en_s || en_n_s) |=> !array_on);
  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (fault_q || !hold_s) |=> !ctl_ready);
  assert_on_needs_ready_R2: assert property (@(posedge clk) disable iff (rst)
    array_on |-> ctl_ready);
  assert_nopwr_dark_R3: assert property (@(posedge clk) disable iff (rst)
    !pwr_s |=> (!array_on && !ctl_ready));
  assert_fault_dark_R4: assert property (@(posedge clk) disable iff (rst)
    fault_q |=> !array_on);
  assert_clear_qualified_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_q) |-> $past(long_low));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (|fault_s) |=> fault_q);
endmodule

bind laser_guard_ctrl laser_guard_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .hold_s(hold_s), .en_s(en_s), .en_n_s(en_n_s),
  .pwr_s(pwr_s), .fault_s(fault_s), .fault_q(fault_q), .long_low(long_low),
  .array_on(array_on), .ctl_ready(ctl_ready)
);

// File: tb/laser_guard_ctrl_tb.sv
module laser_guard_ctrl_tb;
  localparam int NCH = 4;
  localparam int REC = 3;
  localparam int DLY = 5;

  logic clk = 1'b0;
  logic rst, hold_n, emit_en, emit_en_n, pwr_good, us_tick;
  logic [NCH-1:0] fault_vec;
  logic array_on, ctl_ready;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  laser_guard_ctrl #(.NCH(NCH), .SYNC_STAGES(2), .RECOVER_TICKS(REC),
                     .ON_DELAY_TICKS(DLY)) u_dut (
    .clk(clk), .rst(rst), .hold_n(hold_n), .emit_en(emit_en),
    .emit_en_n(emit_en_n), .pwr_good(pwr_good), .fault_vec(fault_vec),
    .us_tick(us_tick), .array_on(array_on), .ctl_ready(ctl_ready)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      us_tick = 1'b1; cyc(1);
      us_tick = 1'b0; cyc(1);
    end
  endtask

  task automatic expect_out(input string req, input logic ea, input logic ec);
    checks += 2;
    if (array_on !== ea) begin
      errors++;
      $display("FAIL %s array_on actual=%b expected=%b at %0t", req, array_on, ea, $time);
    end
    if (ctl_ready !== ec) begin
      errors++;
      $display("FAIL %s ctl_ready actual=%b expected=%b at %0t", req, ctl_ready, ec, $time);
    end
  endtask

  // release hold (assumed already high) through the full on-delay
  task automatic bring_up();
    cyc(6); ticks(DLY); cyc(3);
  endtask

  task automatic recover(input int n);
    hold_n = 1'b0; cyc(4); ticks(n); cyc(3);
    hold_n = 1'b1; bring_up();
  endtask

  initial begin
    fork
      begin
        rst = 1'b1; hold_n = 1'b0; emit_en = 1'b1; emit_en_n = 1'b0;
        pwr_good = 1'b0; us_tick = 1'b0; fault_vec = '0;
        cyc(5);
        expect_out("R9 reset", 1'b0, 1'b0);
        rst = 1'b0;

        // supply not good: ticks do nothing
        hold_n = 1'b1; cyc(6); ticks(DLY + 2); cyc(3);
        expect_out("R3 no supply", 1'b0, 1'b0);

        // on-delay boundary
        pwr_good = 1'b1; cyc(6); ticks(DLY - 1); cyc(3);
        expect_out("R6 one tick short", 1'b0, 1'b0);
        ticks(1); cyc(3);
        expect_out("R6 delay done", 1'b1, 1'b1);

        // enable pin sweep
        for (int e = 0; e < 4; e++) begin
          emit_en = e[0]; emit_en_n = e[1]; cyc(4);
          expect_out("R1 R2 enable combo", e[0] & ~e[1], 1'b1);
        end
        emit_en = 1'b1; emit_en_n = 1'b0; cyc(4);

        // enable removal latency
        emit_en = 1'b0; cyc(2);
        expect_out("R7 enable edge 2", 1'b1, 1'b1);
        cyc(1);
        expect_out("R7 enable edge 3", 1'b0, 1'b1);
        emit_en = 1'b1; cyc(4);

        // hold latency
        hold_n = 1'b0; cyc(2);
        expect_out("R7 hold edge 2", 1'b1, 1'b1);
        cyc(1);
        expect_out("R7 R2 hold edge 3", 1'b0, 1'b0);

        // interrupted delay restarts
        hold_n = 1'b1; cyc(6); ticks(DLY - 1);
        hold_n = 1'b0; cyc(4);
        hold_n = 1'b1; cyc(6); ticks(DLY - 1); cyc(3);
        expect_out("R6 restarted delay", 1'b0, 1'b0);
        ticks(1); cyc(3);
        expect_out("R6 restarted done", 1'b1, 1'b1);

        // supply loss
        pwr_good = 1'b0; cyc(2);
        expect_out("R7 supply edge 2", 1'b1, 1'b1);
        cyc(1);
        expect_out("R3 supply lost", 1'b0, 1'b0);
        pwr_good = 1'b1; bring_up();
        expect_out("R3 supply back", 1'b1, 1'b1);

        // per-lane fault, short and long recovery
        for (int ch = 0; ch < NCH; ch++) begin
          fault_vec = NCH'(1) << ch; cyc(4);
          expect_out("R4 lane fault", 1'b0, 1'b0);
          fault_vec = '0; cyc(4); ticks(DLY + 2);
          expect_out("R4 fault stays", 1'b0, 1'b0);
          recover(REC - 1);
          expect_out("R5 short pulse", 1'b0, 1'b0);
          recover(REC);
          expect_out("R5 long pulse", 1'b1, 1'b1);
        end

        // fault still present at end of recovery
        fault_vec = 4'b1000; cyc(4);
        recover(REC);
        expect_out("R8 set wins", 1'b0, 1'b0);
        fault_vec = '0; cyc(4);
        recover(REC);
        expect_out("R8 after removal", 1'b1, 1'b1);

        // recovery ticks during supply loss do not count
        fault_vec = 4'b0010; cyc(4); fault_vec = '0;
        hold_n = 1'b0; pwr_good = 1'b0; cyc(4); ticks(REC + 2);
        pwr_good = 1'b1; cyc(4);
        hold_n = 1'b1; bring_up();
        expect_out("R5 ticks without supply", 1'b0, 1'b0);
        recover(REC);
        expect_out("R5 proper recovery", 1'b1, 1'b1);

        // synchronous reset while running
        rst = 1'b1; cyc(2);
        expect_out("R9 reset in run", 1'b0, 1'b0);
        rst = 1'b0; cyc(2);
      end
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule